// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block is a watchdog built from a free-running base counter and a postscaler behind it. The base counter spans `2^BASE_W` cycles. The postscaler counts base wraps up to a ratio of `2^n`. The exponent `n` comes from a select input. When the whole chain expires, the block checks whether the core is currently executing code. If it is, the block raises a reset request. If the core is idle or asleep, it raises a wake strobe instead.

Several events clear both stages of the timer:

- the core's watchdog-clear instruction;
- the core's sleep instruction;
- a clock-loss report from an external detector, but only while clock monitoring is enabled;
- a write that changes the internal-oscillator frequency field, but only while the internal oscillator drives the system clock.

A disable input holds the timer at zero and blocks both outputs.

Top module: `mawdt_top`

## Requirements
- R1: While `rst` is high both outputs are low. The first time-out after reset release with the watchdog enabled appears `2^(BASE_W+n)` cycles after the last reset cycle.
- R2: After a clear, the time-out output pulse appears exactly `2^(BASE_W+n)` clock edges after the edge that sampled the clear. Here `n` is the unsigned value of the 4-bit `ps_sel` field (0 to 15).
- R3: A time-out is a reset request when `pwr_mode` is 2'b00 (run) in the expiry cycle. The reset request is a single-cycle pulse on `rst_req_o`.
- R4: A time-out is a wake strobe when `pwr_mode` is 2'b01 (idle), 2'b10 (sleep) or 2'b11 (idle, alternate clock) in the expiry cycle. The wake strobe is a single-cycle pulse on `wake_o`.
- R5: After an expiry both stages restart from zero. Without further clears, the next time-out follows one full period later.
- R6: A high `clr_wdt_i` clears both the base counter and the postscaler.
- R7: A high `clr_sleep_i` clears both the base counter and the postscaler.
- R8: `clk_lost_i` clears the timer when `clk_mon_en` is 1. When `clk_mon_en` is 0, `clk_lost_i` has no effect.
- R9: `osc_wr_i` clears the timer only when `intosc_sys` is 1 and `osc_wdata_i` differs from `osc_cur_i`. In every other case the write has no effect.
- R10: While `wdt_en` is 0 the timer is held at zero and neither output pulses. This holds even if expiry was due in that cycle. Counting restarts from zero in the first enabled cycle.
- R11: A clear in the expiry cycle suppresses that time-out, and the next full period starts from the clear.
- R12: `wake_o` and `rst_req_o` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdt_en | input | 1 | Watchdog enable; 0 holds the timer at zero |
| ps_sel | input | SEL_W | Postscaler exponent n, ratio 2^n |
| pwr_mode | input | 2 | 00 run, 01 idle, 10 sleep, 11 idle (alternate clock) |
| clr_wdt_i | input | 1 | Watchdog-clear instruction strobe |
| clr_sleep_i | input | 1 | Sleep instruction strobe |
| clk_lost_i | input | 1 | Clock-loss indication from the detector |
| clk_mon_en | input | 1 | Clock monitoring enabled |
| osc_wr_i | input | 1 | Write strobe to the oscillator frequency field |
| osc_wdata_i | input | FSEL_W | Value being written to the frequency field |
| osc_cur_i | input | FSEL_W | Current value of the frequency field |
| intosc_sys | input | 1 | Internal oscillator is the system clock |
| wake_o | output | 1 | Wake strobe (core not executing) |
| rst_req_o | output | 1 | Reset request (core executing) |

## Verification
The assertions check the following on every cycle:

- the two outputs are mutually exclusive and each pulse lasts one cycle;
- a reset request only follows a run-mode cycle and a wake only follows a non-run cycle;
- a disabled timer or a clear produces no pulse in the next cycle;
- both stages hold zero after a clear or an expiry.

Only the bench scenarios can show exact period lengths for several ratios and the restart after expiry. They also show the gating of the clock-loss and oscillator-write clears, and the suppression of a time-out by a clear that lands in its expiry cycle. The bench checks these by predicting the cycle of every pulse.

// File: rtl/mawdt_pkg.sv
package mawdt_pkg;

    typedef enum logic [1:0] {
        PM_RUN      = 2'b00,
        PM_IDLE     = 2'b01,
        PM_SLEEP    = 2'b10,
        PM_IDLE_ALT = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic sw;
        logic slp;
        logic clk_loss;
        logic osc;
    } clr_src_t;

    typedef struct packed {
        logic wake;
        logic reset;
    } wd_action_t;

    function automatic logic core_executing(pwr_mode_e m);
        return (m == PM_RUN);
    endfunction

    function automatic logic [31:0] ps_terminal(logic [7:0] sel);
        return (32'd1 << sel) - 32'd1;
    endfunction

    function automatic logic any_clear(clr_src_t s);
        return |s;
    endfunction

endpackage

// File: rtl/mawdt_clear_ctl.sv
module mawdt_clear_ctl
    import mawdt_pkg::*;
#(
    parameter int FSEL_W = 3
) (
    input  logic              sw_clr_i,
    input  logic              slp_clr_i,
    input  logic              clk_lost_i,
    input  logic              clk_mon_en_i,
    input  logic              osc_wr_i,
    input  logic [FSEL_W-1:0] osc_wdata_i,
    input  logic [FSEL_W-1:0] osc_cur_i,
    input  logic              intosc_sys_i,
    output clr_src_t          src_o,
    output logic              clear_o
);

    logic freq_differs;
    assign freq_differs = (osc_wdata_i != osc_cur_i);

    always_comb begin
        src_o.sw       = sw_clr_i;
        src_o.slp      = slp_clr_i;
        src_o.clk_loss = clk_lost_i & clk_mon_en_i;
        src_o.osc      = osc_wr_i & intosc_sys_i & freq_differs;
    end

    assign clear_o = any_clear(src_o);

endmodule

// File: rtl/mawdt_base_ctr.sv
module mawdt_base_ctr #(
    parameter int BASE_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic clear_i,
    output logic tick_o
);

    localparam logic [BASE_W-1:0] LAST = '1;

    logic [BASE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i || clear_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && !clear_i && (cnt_q == LAST);

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (cnt_q == '0)); // R10
    AST_BASE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/mawdt_postscaler.sv
module mawdt_postscaler
    import mawdt_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             expire_o
);

    localparam int PS_W = (1 << SEL_W) - 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] term;

    assign term     = PS_W'(ps_terminal(8'(sel_i)));
    // Compare with >= so that lowering the ratio mid-count expires at once
    assign expire_o = tick_i && (ps_q >= term);

    always_ff @(posedge clk) begin
        if (rst || !run_i || clear_i) begin
            ps_q <= '0;
        end else if (expire_o) begin
            ps_q <= '0;
        end else if (tick_i) begin
            ps_q <= ps_q + 1'b1;
        end
    end

    AST_PS_RESTART: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> (ps_q == '0)); // R5
    AST_PS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (ps_q == '0)); // R7

endmodule

// File: rtl/mawdt_action.sv
module mawdt_action
    import mawdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       expire_i,
    input  pwr_mode_e  mode_i,
    output wd_action_t act_o
);

    wd_action_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            act_q.wake  <= expire_i && !core_executing(mode_i);
            act_q.reset <= expire_i &&  core_executing(mode_i);
        end
    end

    assign act_o = act_q;

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_q)); // R12

endmodule

// File: rtl/mawdt_top.sv
module mawdt_top
    import mawdt_pkg::*;
#(
    parameter int BASE_W = 8,
    parameter int SEL_W  = 4,
    parameter int FSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wdt_en,
    input  logic [SEL_W-1:0]  ps_sel,
    input  logic [1:0]        pwr_mode,
    input  logic              clr_wdt_i,
    input  logic              clr_sleep_i,
    input  logic              clk_lost_i,
    input  logic              clk_mon_en,
    input  logic              osc_wr_i,
    input  logic [FSEL_W-1:0] osc_wdata_i,
    input  logic [FSEL_W-1:0] osc_cur_i,
    input  logic              intosc_sys,
    output logic              wake_o,
    output logic              rst_req_o
);

    pwr_mode_e  mode_e;
    clr_src_t   clr_src;
    logic       clear_any;
    logic       base_tick;
    logic       expire;
    wd_action_t action;

    assign mode_e = pwr_mode_e'(pwr_mode);

    mawdt_clear_ctl #(.FSEL_W(FSEL_W)) u_clear (
        .sw_clr_i     (clr_wdt_i),
        .slp_clr_i    (clr_sleep_i),
        .clk_lost_i   (clk_lost_i),
        .clk_mon_en_i (clk_mon_en),
        .osc_wr_i     (osc_wr_i),
        .osc_wdata_i  (osc_wdata_i),
        .osc_cur_i    (osc_cur_i),
        .intosc_sys_i (intosc_sys),
        .src_o        (clr_src),
        .clear_o      (clear_any)
    );

    mawdt_base_ctr #(.BASE_W(BASE_W)) u_base (
        .clk     (clk),
        .rst     (rst),
        .run_i   (wdt_en),
        .clear_i (clear_any),
        .tick_o  (base_tick)
    );

    mawdt_postscaler #(.SEL_W(SEL_W)) u_ps (
        .clk      (clk),
        .rst      (rst),
        .run_i    (wdt_en),
        .clear_i  (clear_any),
        .tick_i   (base_tick),
        .sel_i    (ps_sel),
        .expire_o (expire)
    );

    mawdt_action u_act (
        .clk      (clk),
        .rst      (rst),
        .expire_i (expire),
        .mode_i   (mode_e),
        .act_o    (action)
    );

    assign wake_o    = action.wake;
    assign rst_req_o = action.reset;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear_any |=> !(wake_o || rst_req_o)); // R11
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> !(wake_o || rst_req_o)); // R10
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wake_o || rst_req_o) |=> !(wake_o || rst_req_o)); // R12
    AST_RESET_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(pwr_mode) == 2'b00)); // R3
    AST_WAKE_NOT_RUN: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> ($past(pwr_mode) != 2'b00)); // R4

endmodule

// File: tb/mawdt_top_test.sv
module mawdt_top_test;

    localparam int BW = 3;
    localparam int SW = 4;
    localparam int FW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wdt_en = 1'b0;
    logic [SW-1:0] ps_sel = '0;
    logic [1:0]    pwr_mode = 2'b00;
    logic          clr_wdt = 1'b0;
    logic          clr_sleep = 1'b0;
    logic          clk_lost = 1'b0;
    logic          clk_mon_en = 1'b0;
    logic          osc_wr = 1'b0;
    logic [FW-1:0] osc_wdata = '0;
    logic [FW-1:0] osc_cur = '0;
    logic          intosc_sys = 1'b0;
    logic          wake;
    logic          rst_req;

    mawdt_top #(.BASE_W(BW), .SEL_W(SW), .FSEL_W(FW)) uut (
        .clk         (clk),
        .rst         (rst),
        .wdt_en      (wdt_en),
        .ps_sel      (ps_sel),
        .pwr_mode    (pwr_mode),
        .clr_wdt_i   (clr_wdt),
        .clr_sleep_i (clr_sleep),
        .clk_lost_i  (clk_lost),
        .clk_mon_en  (clk_mon_en),
        .osc_wr_i    (osc_wr),
        .osc_wdata_i (osc_wdata),
        .osc_cur_i   (osc_cur),
        .intosc_sys  (intosc_sys),
        .wake_o      (wake),
        .rst_req_o   (rst_req)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        bit    is_reset;
        string req;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    int    pulses = 0;
    string ctx = "R1";

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic expect_pulse(int at, bit is_reset, string req);
        exp_t e;
        e.at = at;
        e.is_reset = is_reset;
        e.req = req;
        exp_q.push_back(e);
    endtask

    function automatic int tout(int n);
        return 1 << (BW + n);
    endfunction

    // Monitor: pops predictions and compares them with observed pulses
    always @(negedge clk) begin
        exp_t e;
        while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
            e = exp_q.pop_front();
            check(1'b0, e.req, "missing pulse at cycle", -1, e.at);
        end
        if (!rst && (wake || rst_req)) begin
            pulses++;
            check(!(wake && rst_req), "R12", "both outputs high", 1, 0);
            if (exp_q.size() == 0) begin
                check(1'b0, ctx, "unexpected pulse at cycle", cyc, -1);
            end else begin
                e = exp_q.pop_front();
                check(e.at == cyc, e.req, "pulse cycle", cyc, e.at);
                check(rst_req == e.is_reset, e.req, "pulse kind (1=reset)",
                      int'(rst_req), int'(e.is_reset));
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_past(int c);
        while (cyc <= c) @(negedge clk);
    endtask

    task automatic kick(int n, logic [1:0] mode, bit use_sleep, output int k);
        ps_sel   = SW'(n);
        pwr_mode = mode;
        if (use_sleep) clr_sleep = 1'b1;
        else           clr_wdt   = 1'b1;
        k = cyc;
        @(negedge clk);
        clr_sleep = 1'b0;
        clr_wdt   = 1'b0;
    endtask

    task automatic quiet_window(int n, string req);
        int p0;
        p0 = pulses;
        step(n);
        check(pulses == p0, req, "pulses in quiet window", pulses - p0, 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, ctx, "watchdog expired at cycle", cyc, -1);
        finish_run();
    end

    initial begin
        int k;
        @(negedge clk);
        check(!wake && !rst_req, "R1", "outputs during reset", int'(wake | rst_req), 0);
        step(2);
        check(!wake && !rst_req, "R1", "outputs during reset", int'(wake | rst_req), 0);

        // R1 / R5: first time-out after reset, then periodic restart
        ctx = "R1";
        wdt_en = 1'b1; ps_sel = '0; pwr_mode = 2'b00; rst = 1'b0;
        k = cyc;
        expect_pulse(k + tout(0), 1'b1, "R1");
        expect_pulse(k + 2 * tout(0), 1'b1, "R5");
        wait_past(k + 2 * tout(0));

        // R4: idle mode wakes, R5 repeat
        ctx = "R4";
        kick(1, 2'b01, 1'b0, k);
        expect_pulse(k + 1 + tout(1), 1'b0, "R4");
        expect_pulse(k + 1 + 2 * tout(1), 1'b0, "R5");
        wait_past(k + 1 + 2 * tout(1));

        // R7: sleep instruction clears; sleep mode wakes
        ctx = "R7";
        kick(3, 2'b10, 1'b1, k);
        expect_pulse(k + 1 + tout(3), 1'b0, "R7");
        wait_past(k + 1 + tout(3));

        // R4: alternate idle encoding wakes
        ctx = "R4";
        kick(0, 2'b11, 1'b0, k);
        expect_pulse(k + 1 + tout(0), 1'b0, "R4");
        wait_past(k + 1 + tout(0));

        // R3 / R2: run mode resets, ratio 4
        ctx = "R3";
        kick(2, 2'b00, 1'b0, k);
        expect_pulse(k + 1 + tout(2), 1'b1, "R3");
        expect_pulse(k + 1 + 2 * tout(2), 1'b1, "R2");
        wait_past(k + 1 + 2 * tout(2));

        // R2: larger ratio
        ctx = "R2";
        kick(5, 2'b00, 1'b0, k);
        expect_pulse(k + 1 + tout(5), 1'b1, "R2");
        wait_past(k + 1 + tout(5));

        // R11 / R6: clear lands in the expiry cycle
        ctx = "R11";
        kick(0, 2'b00, 1'b0, k);
        wait_past(k + tout(0) - 1);
        clr_wdt = 1'b1;
        step(1);
        clr_wdt = 1'b0;
        expect_pulse(k + tout(0) + 1 + tout(0), 1'b1, "R6");
        wait_past(k + 2 * tout(0) + 1);

        // R8: clock loss with monitor enabled clears
        ctx = "R8";
        clk_mon_en = 1'b1;
        kick(1, 2'b01, 1'b0, k);
        wait_past(k + 9);
        clk_lost = 1'b1; step(1); clk_lost = 1'b0;
        expect_pulse(k + 11 + tout(1), 1'b0, "R8");
        wait_past(k + 11 + tout(1));

        // R8: clock loss ignored with monitor disabled
        clk_mon_en = 1'b0;
        kick(1, 2'b01, 1'b0, k);
        wait_past(k + 9);
        clk_lost = 1'b1; step(1); clk_lost = 1'b0;
        expect_pulse(k + 1 + tout(1), 1'b0, "R8");
        wait_past(k + 1 + tout(1));

        // R9: frequency change on internal oscillator clears
        ctx = "R9";
        intosc_sys = 1'b1; osc_cur = 3'd3;
        kick(1, 2'b00, 1'b0, k);
        wait_past(k + 9);
        osc_wdata = 3'd5; osc_wr = 1'b1; step(1); osc_wr = 1'b0;
        expect_pulse(k + 11 + tout(1), 1'b1, "R9");
        wait_past(k + 11 + tout(1));

        // R9: write of the same value is ignored
        kick(1, 2'b00, 1'b0, k);
        wait_past(k + 9);
        osc_wdata = 3'd3; osc_wr = 1'b1; step(1); osc_wr = 1'b0;
        expect_pulse(k + 1 + tout(1), 1'b1, "R9");
        wait_past(k + 1 + tout(1));

        // R9: change ignored when another clock drives the system
        intosc_sys = 1'b0;
        kick(1, 2'b00, 1'b0, k);
        wait_past(k + 9);
        osc_wdata = 3'd5; osc_wr = 1'b1; step(1); osc_wr = 1'b0;
        expect_pulse(k + 1 + tout(1), 1'b1, "R9");
        wait_past(k + 1 + tout(1));

        // R10: disabled timer stays quiet, restarts from zero
        ctx = "R10";
        wdt_en = 1'b0;
        quiet_window(300, "R10");
        ps_sel = '0; pwr_mode = 2'b00;
        wdt_en = 1'b1;
        k = cyc;
        expect_pulse(k + tout(0), 1'b1, "R10");
        wait_past(k + tout(0));

        // R10: disable in the expiry cycle blocks the pulse
        kick(0, 2'b00, 1'b0, k);
        wait_past(k + tout(0) - 1);
        wdt_en = 1'b0;
        quiet_window(40, "R10");
        wdt_en = 1'b1;
        k = cyc;
        expect_pulse(k + tout(0), 1'b1, "R10");
        wait_past(k + tout(0));

        wdt_en = 1'b0;
        step(5);
        check(exp_q.size() == 0, "R2", "pending predictions", exp_q.size(), 0);
        finish_run();
    end

endmodule